// File: doc/BRIEF.md
# Codeword Fault Injector

This block sits in a transmit path that carries Reed-Solomon codewords as a stream of 80-bit groups. Each group holds eight 10-bit symbols, and one codeword spans 66 groups. The injector keeps its own count of groups within the current codeword. When an injection mode is active, it flips chosen bits in chosen symbols of one selected group. This lets a downstream decoder and link be tested against known symbol errors.

Three small registers control the block: an enable register, a fault-location register and a bypass register. The fault location is given from coarse to fine. A group number picks one group of the codeword. A symbol mask then picks symbols inside that group. A bit mask then picks bits inside each of those symbols. Continuous mode corrupts every codeword. Single-shot mode corrupts exactly one whole codeword and then clears itself.

Single-shot mode is run by a three-state machine:
- `SHOT_IDLE`: nothing is requested.
- `SHOT_PEND`: a request was written, and the block waits for a codeword start.
- `SHOT_LIVE`: the current codeword is the one being corrupted.

Its transitions are:
- *arm*: a write with the shot bit set, taken from `SHOT_IDLE`.
- *start*: a valid start-of-codeword group, taken from `SHOT_PEND`.
- *finish*: the valid last group (index 65) is processed in `SHOT_LIVE`.
- *cut*: a new codeword start arrives while in `SHOT_LIVE`. That start group is not corrupted.
- *cancel*: a write with the shot bit clear, taken from any state to `SHOT_IDLE`.
- *re-arm*: a write with the shot bit set, in the same cycle as a finish or a cut, goes to `SHOT_PEND`.

Top module: `fec_err_injector`

## Requirements
- R1: After reset, `out_valid`, `out_sof`, `out_hit` and `out_data` are 0, and every register reads 0.
- R2: Register map, on `cfg_addr`:
  - Address 0 (enable): bit 0 is continuous mode and bit 4 is single-shot mode.
  - Address 1 (location): bits [25:16] are the bit mask, bits [15:8] are the symbol mask and bits [6:0] are the group number.
  - Address 2 (bypass): bit 0 is bypass.
  - All other bits, and address 3, read 0. Writes take effect on the clock edge where `cfg_we` is 1, and `cfg_rdata` shows the selected register without delay.
- R3: The outputs follow the inputs by exactly one clock. `out_valid` and `out_sof` are `in_valid` and `in_valid & in_sof` delayed by one cycle.
- R4: A valid group with `in_sof` = 1 has index 0. Each later valid group adds 1 to the index. After index 65 the index wraps to 0, even without `in_sof`.
- R5: When injection is active and the current group index equals the group number, two things happen one cycle later. First, every symbol whose symbol-mask bit is 1 leaves XORed with the bit mask, and the other symbols leave unchanged. Second, `out_hit` is 1 for that group, even when the masks are zero. All other groups pass unchanged with `out_hit` = 0.
- R6: Symbol k of a group occupies data bits [10k+9:10k] and is selected by symbol-mask bit k.
- R7: Single-shot behaviour:
  - A single-shot request made partway through a codeword does nothing until the next codeword start. It then corrupts that whole codeword, once.
  - Enable bit 4 reads 1 from the request until that codeword's group 65 has been processed, and then reads 0.
  - The following codeword is not corrupted.
- R8: Writing the enable register with bit 4 = 0 cancels a pending single shot, and no later codeword is corrupted by it.
- R9: A group number above 65 never matches, so nothing is corrupted and `out_hit` stays 0.
- R10: With bypass = 1, `out_data` equals the input data of the previous cycle and `out_hit` stays 0, whatever the enable register holds.
- R11: Cycles with `in_valid` = 0 neither advance the group index nor raise `out_hit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| in_valid | input | 1 | Input group is valid |
| in_sof | input | 1 | Input group is the first group of a codeword |
| in_data | input | 80 | Input group, eight 10-bit symbols |
| out_valid | output | 1 | Output group is valid |
| out_sof | output | 1 | Output group starts a codeword |
| out_data | output | 80 | Output group, possibly corrupted |
| out_hit | output | 1 | Output group was the target of an injection |

## Verification
The bench builds the block with its default parameters: 10-bit symbols, eight symbols per group and 66 groups per codeword. With these values, a full codeword pass takes only 66 cycles. This brings the wrap from index 65 back to 0 within reach, and also the last group as both a fault target and the end of a single shot. The 7-bit group field can hold 70, which is an out-of-range group number that must never match. The masks cover all-ones, single-bit, alternating and zero patterns, which exercises each symbol position.

// File: rtl/fec_inj_pkg.sv
package fec_inj_pkg;

    localparam int CFG_AW = 2;
    localparam int CFG_DW = 32;

    localparam logic [CFG_AW-1:0] ADDR_ENABLE = 2'd0;
    localparam logic [CFG_AW-1:0] ADDR_LOCATE = 2'd1;
    localparam logic [CFG_AW-1:0] ADDR_BYPASS = 2'd2;

    localparam int EN_CONT_BIT = 0;
    localparam int EN_SHOT_BIT = 4;
    localparam int BYP_BIT     = 0;
    localparam int GRP_LSB     = 0;
    localparam int SYM_LSB     = 8;
    localparam int BIT_LSB     = 16;

    typedef enum logic [1:0] {
        SHOT_IDLE = 2'd0,
        SHOT_PEND = 2'd1,
        SHOT_LIVE = 2'd2
    } shot_state_e;

endpackage

// File: rtl/fec_inj_regs.sv
module fec_inj_regs
    import fec_inj_pkg::*;
#(
    parameter int SYM_W = 10,
    parameter int SYMS  = 8,
    parameter int GRP_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    output logic [CFG_DW-1:0]   cfg_rdata,
    input  logic                shot_busy,
    output logic                shot_wr,
    output logic                shot_wr_val,
    output logic                cont_en,
    output logic                byp,
    output logic [SYM_W-1:0]    bit_mask,
    output logic [SYMS-1:0]     sym_mask,
    output logic [GRP_W-1:0]    grp_sel
);

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    logic wr_en, wr_loc, wr_byp;
    assign wr_en  = cfg_we && (cfg_addr == ADDR_ENABLE);
    assign wr_loc = cfg_we && (cfg_addr == ADDR_LOCATE);
    assign wr_byp = cfg_we && (cfg_addr == ADDR_BYPASS);

    assign shot_wr     = wr_en;
    assign shot_wr_val = cfg_wdata[EN_SHOT_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_en  <= 1'b0;
            byp      <= 1'b0;
            bit_mask <= '0;
            sym_mask <= '0;
            grp_sel  <= '0;
        end else begin
            if (wr_en) begin
                cont_en <= cfg_wdata[EN_CONT_BIT];
            end
            if (wr_byp) begin
                byp <= cfg_wdata[BYP_BIT];
            end
            if (wr_loc) begin
                bit_mask <= cfg_wdata[BIT_LSB +: SYM_W];
                sym_mask <= cfg_wdata[SYM_LSB +: SYMS];
                grp_sel  <= cfg_wdata[GRP_LSB +: GRP_W];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            ADDR_ENABLE: begin
                cfg_rdata[EN_CONT_BIT] = cont_en;
                cfg_rdata[EN_SHOT_BIT] = shot_busy;
            end
            ADDR_LOCATE: begin
                cfg_rdata[BIT_LSB +: SYM_W] = bit_mask;
                cfg_rdata[SYM_LSB +: SYMS]  = sym_mask;
                cfg_rdata[GRP_LSB +: GRP_W] = grp_sel;
            end
            ADDR_BYPASS: begin
                cfg_rdata[BYP_BIT] = byp;
            end
            default: cfg_rdata = '0;
        endcase
    end

    AST_LOC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_loc |=> (grp_sel == $past(cfg_wdata[GRP_LSB +: GRP_W]))) else $error("location write lost"); // R2

endmodule

// File: rtl/fec_inj_grp_cnt.sv
module fec_inj_grp_cnt #(
    parameter int GRPS  = 66,
    parameter int GRP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic [GRP_W-1:0] grp_idx,
    output logic             grp_last
);

    localparam logic [GRP_W-1:0] LAST_IDX = GRP_W'(GRPS - 1);

    logic [GRP_W-1:0] cnt_q;

    assign grp_idx  = in_sof ? '0 : cnt_q;
    assign grp_last = (grp_idx == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= grp_last ? '0 : grp_idx + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX) else $error("group count out of range"); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt_q)) else $error("count moved on idle cycle"); // R11
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && grp_last) |=> (cnt_q == '0)) else $error("count did not wrap"); // R4

endmodule

// File: rtl/fec_inj_shot_fsm.sv
module fec_inj_shot_fsm
    import fec_inj_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shot_wr,
    input  logic shot_wr_val,
    input  logic in_valid,
    input  logic in_sof,
    input  logic grp_last,
    output logic shot_live,
    output logic shot_busy
);

    shot_state_e state_q, state_d, base_d;

    logic start_seen;
    assign start_seen = in_valid && in_sof;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SHOT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        base_d = state_q;
        unique case (state_q)
            SHOT_IDLE: base_d = SHOT_IDLE;
            SHOT_PEND: base_d = start_seen ? SHOT_LIVE : SHOT_PEND;
            SHOT_LIVE: begin
                if (start_seen) begin
                    base_d = SHOT_IDLE;
                end else if (in_valid && grp_last) begin
                    base_d = SHOT_IDLE;
                end else begin
                    base_d = SHOT_LIVE;
                end
            end
            default: base_d = SHOT_IDLE;
        endcase

        state_d = base_d;
        if (shot_wr) begin
            if (!shot_wr_val) begin
                state_d = SHOT_IDLE;
            end else if (base_d == SHOT_IDLE) begin
                state_d = SHOT_PEND;
            end
        end
    end

    always_comb begin
        shot_live = 1'b0;
        shot_busy = 1'b0;
        unique case (state_q)
            SHOT_IDLE: begin
                shot_live = 1'b0;
                shot_busy = 1'b0;
            end
            SHOT_PEND: begin
                shot_live = start_seen;
                shot_busy = 1'b1;
            end
            SHOT_LIVE: begin
                shot_live = !start_seen;
                shot_busy = 1'b1;
            end
            default: begin
                shot_live = 1'b0;
                shot_busy = 1'b0;
            end
        endcase
    end

    AST_SHOT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SHOT_LIVE && in_valid && grp_last && !shot_wr) |=> (state_q == SHOT_IDLE)) else $error("shot did not finish"); // R7
    AST_SHOT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SHOT_PEND && !start_seen && !shot_wr) |=> (state_q == SHOT_PEND)) else $error("shot left pending early"); // R7
    AST_SHOT_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (shot_wr && !shot_wr_val) |=> (state_q == SHOT_IDLE)) else $error("cancel ignored"); // R8

endmodule

// File: rtl/fec_inj_xor.sv
module fec_inj_xor #(
    parameter int SYM_W = 10,
    parameter int SYMS  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  logic [SYM_W*SYMS-1:0] in_data,
    input  logic                  hit,
    input  logic [SYM_W-1:0]      bit_mask,
    input  logic [SYMS-1:0]       sym_mask,
    output logic                  out_valid,
    output logic                  out_sof,
    output logic [SYM_W*SYMS-1:0] out_data,
    output logic                  out_hit
);

    localparam int DATA_W = SYM_W * SYMS;

    logic [DATA_W-1:0] flip;

    for (genvar k = 0; k < SYMS; k++) begin : g_sym
        assign flip[k*SYM_W +: SYM_W] = (hit && sym_mask[k]) ? bit_mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= '0;
            out_hit   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_valid && in_sof;
            out_data  <= in_data ^ flip;
            out_hit   <= hit;
        end
    end

    AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (out_data == $past(in_data))) else $error("data altered without hit"); // R5
    AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> out_valid) else $error("hit on idle cycle"); // R11

endmodule

// File: rtl/fec_err_injector.sv
module fec_err_injector
    import fec_inj_pkg::*;
#(
    parameter int SYM_W = 10,
    parameter int SYMS  = 8,
    parameter int GRPS  = 66
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  logic [SYM_W*SYMS-1:0] in_data,
    output logic                  out_valid,
    output logic                  out_sof,
    output logic [SYM_W*SYMS-1:0] out_data,
    output logic                  out_hit
);

    localparam int GRP_W = $clog2(GRPS);

    logic             shot_wr, shot_wr_val, shot_live, shot_busy;
    logic             cont_en, byp, grp_last, hit;
    logic [SYM_W-1:0] bit_mask;
    logic [SYMS-1:0]  sym_mask;
    logic [GRP_W-1:0] grp_sel, grp_idx;

    fec_inj_regs #(.SYM_W(SYM_W), .SYMS(SYMS), .GRP_W(GRP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .shot_busy(shot_busy),
        .shot_wr(shot_wr), .shot_wr_val(shot_wr_val), .cont_en(cont_en),
        .byp(byp), .bit_mask(bit_mask), .sym_mask(sym_mask), .grp_sel(grp_sel)
    );

    fec_inj_grp_cnt #(.GRPS(GRPS), .GRP_W(GRP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .grp_idx(grp_idx), .grp_last(grp_last)
    );

    fec_inj_shot_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .shot_wr(shot_wr), .shot_wr_val(shot_wr_val),
        .in_valid(in_valid), .in_sof(in_sof), .grp_last(grp_last),
        .shot_live(shot_live), .shot_busy(shot_busy)
    );

    assign hit = in_valid && !byp && (cont_en || shot_live) && (grp_idx == grp_sel);

    fec_inj_xor #(.SYM_W(SYM_W), .SYMS(SYMS)) u_xor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .hit(hit), .bit_mask(bit_mask), .sym_mask(sym_mask),
        .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data), .out_hit(out_hit)
    );

    AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_sel > GRP_W'(GRPS - 1)) |=> !out_hit) else $error("out-of-range group hit"); // R9
    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        byp |=> !out_hit) else $error("hit under bypass"); // R10
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid not delayed by one"); // R3

endmodule

// File: tb/fec_err_injector_bench.sv
`timescale 1ns/1ps
module fec_err_injector_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        in_valid, in_sof;
    logic [79:0] in_data;
    logic        out_valid, out_sof, out_hit;
    logic [79:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int hits  = 0;

    always #10 clk = ~clk;

    fec_err_injector u_fec_err_injector (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
        .out_sof(out_sof), .out_data(out_data), .out_hit(out_hit)
    );

    localparam int NVEC = 6;
    localparam logic [31:0] VEC_LOC [NVEC] = '{
        32'h03FF_FF00, 32'h0001_0141, 32'h0200_8021,
        32'h0155_A507, 32'h0000_FF0A, 32'h02AA_0003
    };

    task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [79:0] pattern(input int seed, input int g);
        logic [79:0] d;
        for (int k = 0; k < 8; k++) d[k*10 +: 10] = 10'(seed * 37 + g * 11 + k * 5 + 3);
        return d;
    endfunction

    function automatic logic [79:0] corrupt(input logic [79:0] d, input logic [31:0] loc);
        logic [79:0] r = d;
        for (int k = 0; k < 8; k++) if (loc[8 + k]) r[k*10 +: 10] = r[k*10 +: 10] ^ loc[25:16];
        return r;
    endfunction

    task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp, tag, 80'(cfg_rdata), 80'(exp));
    endtask

    task automatic send_group(input logic [79:0] d, input bit sof, input bit exp_hit,
                              input logic [79:0] exp_d, input string tag);
        in_valid = 1'b1; in_sof = sof; in_data = d;
        @(negedge clk);
        if (out_hit) hits++;
        check(out_data == exp_d, tag, out_data, exp_d);
        check({out_valid, out_sof, out_hit} == {1'b1, sof, exp_hit}, {tag, "/R3 flags"},
              80'({out_valid, out_sof, out_hit}), 80'({1'b1, sof, exp_hit}));
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic send_range(input int seed, input int g0, input int g1, input bit act,
                              input logic [31:0] loc, input string tag);
        int exp_hits;
        hits = 0;
        exp_hits = (act && int'(loc[6:0]) >= g0 && int'(loc[6:0]) <= g1) ? 1 : 0;
        for (int g = g0; g <= g1; g++) begin
            bit eh;
            logic [79:0] d;
            eh = act && (g == int'(loc[6:0]));
            d  = pattern(seed, g);
            send_group(d, g == 0, eh, eh ? corrupt(d, loc) : d, tag);
        end
        check(hits == exp_hits, {tag, " hit count"}, 80'(hits), 80'(exp_hits));
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        in_valid = 1'b0; in_sof = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        check({out_valid, out_sof, out_hit} == 3'b000 && out_data == '0, "R1 outputs",
              out_data, 80'(0));
        cfg_chk(2'd0, 32'h0, "R1 enable");
        cfg_chk(2'd1, 32'h0, "R1 location");
        cfg_chk(2'd2, 32'h0, "R1 bypass");
        rst_n = 1'b1;

        // R2 register map and reserved bits
        cfg_wr(2'd1, 32'hFFFF_FFFF); cfg_chk(2'd1, 32'h03FF_FF7F, "R2 location");
        cfg_wr(2'd2, 32'hFFFF_FFFF); cfg_chk(2'd2, 32'h1, "R2 bypass set");
        cfg_wr(2'd2, 32'h0);         cfg_chk(2'd2, 32'h0, "R2 bypass clear");
        cfg_wr(2'd0, 32'hFFFF_FFEF); cfg_chk(2'd0, 32'h1, "R2 enable");
        cfg_wr(2'd0, 32'h0);         cfg_chk(2'd0, 32'h0, "R2 enable clear");
        cfg_chk(2'd3, 32'h0, "R2 unused address");

        // R5 R6 vector table in continuous mode
        cfg_wr(2'd0, 32'h1);
        for (int i = 0; i < NVEC; i++) begin
            cfg_wr(2'd1, VEC_LOC[i]);
            cfg_chk(2'd1, VEC_LOC[i], "R2 location readback");
            send_range(i + 1, 0, 65, 1'b1, VEC_LOC[i], "R5 R6 vector");
        end

        // R4 wrap after group 65 without a start marker
        cfg_wr(2'd1, 32'h03FF_0100);
        send_range(20, 0, 65, 1'b1, 32'h03FF_0100, "R4 codeword");
        send_group(pattern(21, 0), 1'b0, 1'b1, corrupt(pattern(21, 0), 32'h03FF_0100), "R4 wrap hit");
        send_group(pattern(21, 1), 1'b0, 1'b0, pattern(21, 1), "R4 after wrap");

        // R11 idle cycles do not advance the index
        cfg_wr(2'd1, 32'h0155_3302);
        send_group(pattern(30, 0), 1'b1, 1'b0, pattern(30, 0), "R11 g0");
        send_group(pattern(30, 1), 1'b0, 1'b0, pattern(30, 1), "R11 g1");
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check({out_valid, out_hit} == 2'b00, "R11 idle", 80'({out_valid, out_hit}), 80'(0));
        end
        send_group(pattern(30, 2), 1'b0, 1'b1, corrupt(pattern(30, 2), 32'h0155_3302), "R11 g2 hit");
        cfg_wr(2'd0, 32'h0);

        // R7 single shot requested mid-codeword
        cfg_wr(2'd1, 32'h03FF_FF14);
        send_range(40, 0, 9, 1'b0, 32'h03FF_FF14, "R7 head");
        cfg_wr(2'd0, 32'h10);
        cfg_chk(2'd0, 32'h10, "R7 pending reads 1");
        send_range(40, 10, 65, 1'b0, 32'h03FF_FF14, "R7 rest of codeword");
        cfg_chk(2'd0, 32'h10, "R7 still pending");
        send_range(41, 0, 65, 1'b1, 32'h03FF_FF14, "R7 shot codeword");
        cfg_chk(2'd0, 32'h0, "R7 self clear");
        send_range(42, 0, 65, 1'b0, 32'h03FF_FF14, "R7 no repeat");

        // R8 cancel a pending shot
        cfg_wr(2'd0, 32'h10);
        cfg_wr(2'd0, 32'h0);
        cfg_chk(2'd0, 32'h0, "R8 cancel reads 0");
        send_range(50, 0, 65, 1'b0, 32'h03FF_FF14, "R8 no injection");

        // R9 group number above 65
        cfg_wr(2'd1, 32'h03FF_FF46);
        cfg_wr(2'd0, 32'h1);
        send_range(60, 0, 65, 1'b0, 32'h03FF_FF46, "R9 out of range");

        // R10 bypass overrides continuous mode
        cfg_wr(2'd1, 32'h03FF_FF05);
        cfg_wr(2'd2, 32'h1);
        send_range(70, 0, 65, 1'b0, 32'h03FF_FF05, "R10 bypass");
        cfg_wr(2'd2, 32'h0);
        send_range(71, 0, 65, 1'b1, 32'h03FF_FF05, "R10 bypass released");
        cfg_wr(2'd0, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule